// File: doc/BRIEF.md
# Shared-Bus Arbiter and Interconnect

This block joins a parameterised number of bus masters to a parameterised number of slaves over one shared, pipelined bus with AHB-style signalling. A fixed-priority arbiter picks which master owns the address phase. A decoder turns the upper address bits into a slave select. Two multiplexers then route the traffic. The forward one carries address, control and write data to the slaves. The return one carries read data, the ready flag and the response code back to the masters.

Address and data phases overlap. The write-data path and the read-return path both follow owners that were registered one ready cycle earlier than the address-phase owner. So one master can present its next address while another is still finishing its data beat.

Slave responses pass through unchanged, including wait states, error, retry and split. A master whose transfer is split leaves arbitration until one of the slaves raises that master's resume bit. When no master is eligible, ownership parks on master 0, which is expected to drive idle transfers.

Top module: `ahb_shared_bus`

## Requirements
- R1: While `rst` is high every output of the block is zero, whatever the inputs are.
- R2: The slave index is the top ceil(log2 N_SLV) bits of `s_addr`, read as an unsigned binary number; index k below N_SLV raises only `s_sel[k]`, and an index of N_SLV or more raises no select.
- R3: `s_addr`, `s_trans`, `s_write` come from the current address-phase owner, and `s_master` shows that owner's number.
- R4: Arbitration is fixed priority, with the lowest-numbered eligible requester winning. `m_grant` is one-hot and changes only at a clock edge where `bus_ready` is high.
- R5: At a ready edge with no eligible requester, ownership moves to master 0.
- R6: `s_wdata` comes from the master that owned the address phase at the previous ready edge.
- R7: During an active data phase to a mapped slave, `m_rdata`, `bus_ready` and `m_resp` are taken from the slave whose index was registered at the ready edge that ended the address phase. Responses pass through unchanged: OKAY=00, ERROR=01, RETRY=10, SPLIT=11.
- R8: When the previous address phase carried no transfer (`s_trans` IDLE=00 or BUSY=01; NONSEQ=10 and SEQ=11 are transfers), the data phase reports `bus_ready`=1, `m_resp`=OKAY and `m_rdata`=0.
- R9: A transfer addressed to an unmapped index gets a single-cycle data phase with `bus_ready`=1, `m_resp`=ERROR and `m_rdata`=0.
- R10: A master whose active data phase sees SPLIT is excluded from arbitration from the next edge onward. It becomes eligible again after an edge where some slave raises `s_resume[s*N_MST+m]`. When a split and a resume for the same master arrive together, the split wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | N_MST | Bus request, one bit per master |
| m_addr | input | N_MST*AW | Addresses, master m at bits m*AW |
| m_trans | input | 2*N_MST | Transfer type per master |
| m_write | input | N_MST | Write flag per master |
| m_wdata | input | N_MST*DW | Write data per master |
| m_grant | output | N_MST | One-hot ownership of the address phase |
| m_rdata | output | DW | Read data returned to masters |
| bus_ready | output | 1 | Shared ready to masters and slaves |
| m_resp | output | 2 | Response returned to masters |
| s_sel | output | N_SLV | Slave selects |
| s_addr | output | AW | Address to slaves |
| s_trans | output | 2 | Transfer type to slaves |
| s_write | output | 1 | Write flag to slaves |
| s_wdata | output | DW | Write data to slaves |
| s_master | output | ceil(log2 N_MST) | Current address-phase owner |
| s_rdata | input | N_SLV*DW | Read data, slave s at bits s*DW |
| s_ready | input | N_SLV | Ready per slave |
| s_resp | input | 2*N_SLV | Response per slave |
| s_resume | input | N_SLV*N_MST | Split resume bits, bit s*N_MST+m |

## Verification
The bench builds the block with three masters and three slaves, using 8-bit addresses and 8-bit data. Three masters give a real priority order, with a middle master that can both win and lose. Three slaves with a two-bit index leave index 3 unmapped, which makes the error path of R9 reachable. A directed split-and-resume sequence is followed by a long random run with random requests, wait states, responses and resume pulses. That run mixes owners changing between the address and data phases with masters that are masked and unmasked.

// File: rtl/ahb_ic_pkg.sv
package ahb_ic_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } resp_e;

    // data-phase bookkeeping carried from the address phase
    typedef struct packed {
        logic act;   // transfer to a mapped slave
        logic bad;   // transfer to an unmapped index
    } dphase_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic is_xfer(input logic [1:0] t);
        return t[1];
    endfunction

endpackage

// File: rtl/ahb_arbiter.sv
module ahb_arbiter import ahb_ic_pkg::*; #(
    parameter int N_MST = 3,
    parameter int N_SLV = 3,
    parameter int MW    = idx_bits(N_MST)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_ready,
    input  logic [N_MST-1:0]         req,
    input  logic                     split_seen,
    input  logic [N_SLV*N_MST-1:0]   resume,
    output logic [MW-1:0]            owner,
    output logic [MW-1:0]            downer
);

    logic [N_MST-1:0] mask_q, mask_nxt, elig, resumed;
    logic [MW-1:0]    owner_q, downer_q, winner;

    always_comb begin
        for (int i = 0; i < N_MST; i++) begin
            resumed[i] = 1'b0;
            for (int s = 0; s < N_SLV; s++)
                resumed[i] = resumed[i] | resume[s*N_MST + i];
        end
    end

    assign elig = req & ~mask_q;

    always_comb begin
        winner = '0;
        for (int i = N_MST-1; i >= 0; i--)
            if (elig[i]) winner = MW'(i);
    end

    always_comb begin
        for (int i = 0; i < N_MST; i++) begin
            if (split_seen && downer_q == MW'(i))
                mask_nxt[i] = 1'b1;
            else if (resumed[i])
                mask_nxt[i] = 1'b0;
            else
                mask_nxt[i] = mask_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q  <= '0;
            downer_q <= '0;
            mask_q   <= '0;
        end else begin
            mask_q <= mask_nxt;
            if (bus_ready) begin
                owner_q  <= winner;
                downer_q <= owner_q;
            end
        end
    end

    assign owner  = owner_q;
    assign downer = downer_q;

    // checker state: eligibility seen at the previous edge
    logic [N_MST-1:0] elig_q;
    always_ff @(posedge clk) begin
        if (rst) elig_q <= '0;
        else     elig_q <= elig;
    end

    p_grant_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |=> owner_q == $past(owner_q));

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ready && (|elig) |=>
            elig_q[owner_q] && ((elig_q & ((N_MST'(1) << owner_q) - N_MST'(1))) == '0));

    p_park_zero_r5: assert property (@(posedge clk) disable iff (rst)
        bus_ready && !(|elig) |=> owner_q == '0);

    p_split_masks_r10: assert property (@(posedge clk) disable iff (rst)
        split_seen |=> mask_q[$past(downer_q)]);

endmodule

// File: rtl/ahb_decoder.sv
module ahb_decoder import ahb_ic_pkg::*; #(
    parameter int N_SLV = 3,
    parameter int AW    = 16,
    parameter int SB    = idx_bits(N_SLV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    output logic [SB-1:0]    idx,
    output logic             hit,
    output logic [N_SLV-1:0] sel
);

    assign idx = addr[AW-1 -: SB];
    assign hit = ({1'b0, idx} < (SB+1)'(N_SLV));

    for (genvar k = 0; k < N_SLV; k++) begin : g_sel
        assign sel[k] = hit && (idx == SB'(k));
    end

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/ahb_m2s_mux.sv
module ahb_m2s_mux #(
    parameter int N_MST = 3,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int MW    = 2
) (
    input  logic [N_MST*AW-1:0] m_addr,
    input  logic [2*N_MST-1:0]  m_trans,
    input  logic [N_MST-1:0]    m_write,
    input  logic [N_MST*DW-1:0] m_wdata,
    input  logic [MW-1:0]       owner,
    input  logic [MW-1:0]       downer,
    output logic [AW-1:0]       addr,
    output logic [1:0]          trans,
    output logic                write,
    output logic [DW-1:0]       wdata
);

    // address/control follow the address-phase owner,
    // write data follows the delayed (data-phase) owner
    assign addr  = m_addr[owner*AW +: AW];
    assign trans = m_trans[owner*2 +: 2];
    assign write = m_write[owner];
    assign wdata = m_wdata[downer*DW +: DW];

endmodule

// File: rtl/ahb_s2m_mux.sv
module ahb_s2m_mux import ahb_ic_pkg::*; #(
    parameter int N_SLV = 3,
    parameter int DW    = 32,
    parameter int SB    = idx_bits(N_SLV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SB-1:0]      a_idx,
    input  logic               a_hit,
    input  logic               a_active,
    input  logic [N_SLV*DW-1:0] s_rdata,
    input  logic [N_SLV-1:0]   s_ready,
    input  logic [2*N_SLV-1:0] s_resp,
    output logic [DW-1:0]      rdata,
    output logic               ready,
    output logic [1:0]         resp,
    output logic               split_seen
);

    dphase_t       dp_q;
    logic [SB-1:0] dslv_q;

    always_comb begin
        if (dp_q.act) begin
            rdata = s_rdata[dslv_q*DW +: DW];
            ready = s_ready[dslv_q];
            resp  = s_resp[dslv_q*2 +: 2];
        end else if (dp_q.bad) begin
            rdata = '0;
            ready = 1'b1;
            resp  = RS_ERROR;
        end else begin
            rdata = '0;
            ready = 1'b1;
            resp  = RS_OKAY;
        end
    end

    assign split_seen = dp_q.act && (resp == RS_SPLIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q   <= '0;
            dslv_q <= '0;
        end else if (ready) begin
            dp_q.act <= a_active && a_hit;
            dp_q.bad <= a_active && !a_hit;
            dslv_q   <= a_idx;
        end
    end

    p_idle_okay_r8: assert property (@(posedge clk) disable iff (rst)
        ready && !a_active |=> ready && resp == RS_OKAY && rdata == '0);

    p_unmapped_err_r9: assert property (@(posedge clk) disable iff (rst)
        ready && a_active && !a_hit |=> ready && resp == RS_ERROR && rdata == '0);

endmodule

// File: rtl/ahb_shared_bus.sv
module ahb_shared_bus import ahb_ic_pkg::*; #(
    parameter int N_MST = 3,
    parameter int N_SLV = 3,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [N_MST-1:0]               m_req,
    input  logic [N_MST*AW-1:0]            m_addr,
    input  logic [2*N_MST-1:0]             m_trans,
    input  logic [N_MST-1:0]               m_write,
    input  logic [N_MST*DW-1:0]            m_wdata,
    output logic [N_MST-1:0]               m_grant,
    output logic [DW-1:0]                  m_rdata,
    output logic                           bus_ready,
    output logic [1:0]                     m_resp,
    output logic [N_SLV-1:0]               s_sel,
    output logic [AW-1:0]                  s_addr,
    output logic [1:0]                     s_trans,
    output logic                           s_write,
    output logic [DW-1:0]                  s_wdata,
    output logic [idx_bits(N_MST)-1:0]     s_master,
    input  logic [N_SLV*DW-1:0]            s_rdata,
    input  logic [N_SLV-1:0]               s_ready,
    input  logic [2*N_SLV-1:0]             s_resp,
    input  logic [N_SLV*N_MST-1:0]         s_resume
);

    localparam int MW = idx_bits(N_MST);
    localparam int SB = idx_bits(N_SLV);

    logic [MW-1:0]    owner, downer;
    logic             rdy, split_seen, hit;
    logic [SB-1:0]    idx;
    logic [N_SLV-1:0] sel;
    logic [AW-1:0]    addr_i;
    logic [1:0]       trans_i, resp_i;
    logic             write_i;
    logic [DW-1:0]    wdata_i, rdata_i;

    ahb_arbiter #(.N_MST(N_MST), .N_SLV(N_SLV), .MW(MW)) u_arb (
        .clk(clk), .rst(rst), .bus_ready(rdy), .req(m_req),
        .split_seen(split_seen), .resume(s_resume),
        .owner(owner), .downer(downer)
    );

    ahb_m2s_mux #(.N_MST(N_MST), .AW(AW), .DW(DW), .MW(MW)) u_fwd (
        .m_addr(m_addr), .m_trans(m_trans), .m_write(m_write), .m_wdata(m_wdata),
        .owner(owner), .downer(downer),
        .addr(addr_i), .trans(trans_i), .write(write_i), .wdata(wdata_i)
    );

    ahb_decoder #(.N_SLV(N_SLV), .AW(AW), .SB(SB)) u_dec (
        .clk(clk), .rst(rst), .addr(addr_i), .idx(idx), .hit(hit), .sel(sel)
    );

    ahb_s2m_mux #(.N_SLV(N_SLV), .DW(DW), .SB(SB)) u_ret (
        .clk(clk), .rst(rst), .a_idx(idx), .a_hit(hit),
        .a_active(is_xfer(trans_i)),
        .s_rdata(s_rdata), .s_ready(s_ready), .s_resp(s_resp),
        .rdata(rdata_i), .ready(rdy), .resp(resp_i), .split_seen(split_seen)
    );

    // every output forced low while reset is held
    assign m_grant   = rst ? '0 : (N_MST'(1) << owner);
    assign m_rdata   = rst ? '0 : rdata_i;
    assign bus_ready = rst ? 1'b0 : rdy;
    assign m_resp    = rst ? '0 : resp_i;
    assign s_sel     = rst ? '0 : sel;
    assign s_addr    = rst ? '0 : addr_i;
    assign s_trans   = rst ? '0 : trans_i;
    assign s_write   = rst ? 1'b0 : write_i;
    assign s_wdata   = rst ? '0 : wdata_i;
    assign s_master  = rst ? '0 : owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_reset_quiet_r1: assert (m_grant == '0 && m_rdata == '0 && !bus_ready &&
                                      m_resp == '0 && s_sel == '0 && s_addr == '0 &&
                                      s_trans == '0 && !s_write && s_wdata == '0 &&
                                      s_master == '0);
        end
    end

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot(m_grant));

endmodule

// File: tb/tb_ahb_shared_bus.sv
module tb_ahb_shared_bus;
    import ahb_ic_pkg::*;

    localparam int NM = 3, NS = 3, AW = 8, DW = 8, MW = 2, SB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // stimulus
    logic [NM-1:0]    req = '0;
    logic [AW-1:0]    addr [NM];
    logic [1:0]       trans [NM];
    logic [NM-1:0]    wr = '0;
    logic [DW-1:0]    wd [NM];
    logic [DW-1:0]    sd [NS];
    logic [NS-1:0]    srdy = '1;
    logic [1:0]       sresp [NS];
    logic [NS*NM-1:0] resume = '0;

    logic [NM*AW-1:0] m_addr;
    logic [2*NM-1:0]  m_trans;
    logic [NM*DW-1:0] m_wdata;
    logic [NS*DW-1:0] s_rdata;
    logic [2*NS-1:0]  s_resp;

    always_comb begin
        for (int i = 0; i < NM; i++) begin
            m_addr[i*AW +: AW]  = addr[i];
            m_trans[i*2 +: 2]   = trans[i];
            m_wdata[i*DW +: DW] = wd[i];
        end
        for (int s = 0; s < NS; s++) begin
            s_rdata[s*DW +: DW] = sd[s];
            s_resp[s*2 +: 2]    = sresp[s];
        end
    end

    logic [NM-1:0] m_grant;
    logic [DW-1:0] m_rdata;
    logic          bus_ready;
    logic [1:0]    m_resp;
    logic [NS-1:0] s_sel;
    logic [AW-1:0] s_addr;
    logic [1:0]    s_trans;
    logic          s_write;
    logic [DW-1:0] s_wdata;
    logic [MW-1:0] s_master;

    ahb_shared_bus #(.N_MST(NM), .N_SLV(NS), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .m_req(req), .m_addr(m_addr), .m_trans(m_trans),
        .m_write(wr), .m_wdata(m_wdata), .m_grant(m_grant), .m_rdata(m_rdata),
        .bus_ready(bus_ready), .m_resp(m_resp), .s_sel(s_sel), .s_addr(s_addr),
        .s_trans(s_trans), .s_write(s_write), .s_wdata(s_wdata), .s_master(s_master),
        .s_rdata(s_rdata), .s_ready(srdy), .s_resp(s_resp), .s_resume(resume)
    );

    // reference model state
    int mo = 0, mdo = 0, mds = 0, mact = 0, mbad = 0;
    int mmask [NM];
    int e_rdy;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int eidx;
        logic [AW-1:0] ea;
        logic [DW-1:0] erd;
        int eresp;
        ea   = addr[mo];
        eidx = int'(ea >> (AW - SB));
        chk("R4 R5 R10 grant", 64'(m_grant), 64'(1 << mo));
        chk("R3 address", 64'(s_addr), 64'(ea));
        chk("R3 trans", 64'(s_trans), 64'(trans[mo]));
        chk("R3 write", 64'(s_write), 64'(wr[mo]));
        chk("R3 master", 64'(s_master), 64'(mo));
        chk("R2 select", 64'(s_sel), (eidx < NS) ? 64'(1 << eidx) : 64'(0));
        chk("R6 wdata", 64'(s_wdata), 64'(wd[mdo]));
        if (mact != 0) begin
            erd = sd[mds]; e_rdy = int'(srdy[mds]); eresp = int'(sresp[mds]);
            chk("R7 rdata", 64'(m_rdata), 64'(erd));
            chk("R7 ready", 64'(bus_ready), 64'(e_rdy));
            chk("R7 resp", 64'(m_resp), 64'(eresp));
        end else if (mbad != 0) begin
            e_rdy = 1;
            chk("R9 rdata", 64'(m_rdata), 64'(0));
            chk("R9 ready", 64'(bus_ready), 64'(1));
            chk("R9 resp", 64'(m_resp), 64'(1));
        end else begin
            e_rdy = 1;
            chk("R8 rdata", 64'(m_rdata), 64'(0));
            chk("R8 ready", 64'(bus_ready), 64'(1));
            chk("R8 resp", 64'(m_resp), 64'(0));
        end
    endtask

    task automatic model_step();
        int win, eidx, setm;
        int nm [NM];
        eidx = int'(addr[mo] >> (AW - SB));
        setm = (mact != 0 && sresp[mds] == 2'b11) ? mdo : -1;
        for (int m = 0; m < NM; m++) begin
            int res = 0;
            for (int s = 0; s < NS; s++) if (resume[s*NM + m]) res = 1;
            nm[m] = (m == setm) ? 1 : (res != 0 ? 0 : mmask[m]);
        end
        if (e_rdy != 0) begin
            win = 0;
            for (int m = NM-1; m >= 0; m--) if (req[m] && mmask[m] == 0) win = m;
            mdo  = mo;
            mo   = win;
            mds  = eidx;
            mact = (trans[mo == win ? mdo : mdo][1] && eidx < NS) ? 1 : 0;
            mbad = (trans[mdo][1] && eidx >= NS) ? 1 : 0;
        end
        for (int m = 0; m < NM; m++) mmask[m] = nm[m];
    endtask

    task automatic tick();
        #1;
        if (rst) begin
            chk("R1 grant", 64'(m_grant), 0);
            chk("R1 rdata", 64'(m_rdata), 0);
            chk("R1 ready", 64'(bus_ready), 0);
            chk("R1 resp", 64'(m_resp), 0);
            chk("R1 sel", 64'(s_sel), 0);
            chk("R1 addr", 64'(s_addr), 0);
            chk("R1 trans", 64'(s_trans), 0);
            chk("R1 write", 64'(s_write), 0);
            chk("R1 wdata", 64'(s_wdata), 0);
            chk("R1 master", 64'(s_master), 0);
        end else begin
            compare();
        end
        @(posedge clk);
        if (!rst) model_step();
        @(negedge clk);
    endtask

    task automatic slaves_default();
        for (int s = 0; s < NS; s++) begin
            sd[s] = DW'(8'hA0 + s); sresp[s] = 2'b00;
        end
        srdy = '1; resume = '0;
    endtask

    initial begin
        for (int m = 0; m < NM; m++) begin
            mmask[m] = 0; addr[m] = AW'(8'hC3 + m); trans[m] = 2'b10; wd[m] = DW'(8'h55 + m);
        end
        slaves_default();
        req = '1; wr = '1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) tick();
        rst = 1'b0;
        for (int m = 0; m < NM; m++) trans[m] = 2'b00;
        req = '0; wr = '0;
        tick(); tick();

        // priority and pipelined ownership
        req = 3'b110;
        for (int m = 0; m < NM; m++) begin
            addr[m] = AW'((m << 6) | 5); trans[m] = 2'b10; wd[m] = DW'(16 * m + 1);
        end
        tick(); tick();
        chk("R4 middle master wins", 64'(m_grant), 64'(3'b010));
        req = 3'b111; tick(); tick();
        chk("R4 master 0 wins", 64'(m_grant), 64'(3'b001));
        // unmapped index 3
        addr[0] = 8'hC0; tick(); tick();
        req = '0; tick(); tick();
        chk("R5 parked", 64'(m_grant), 64'(3'b001));

        // split sequence on master 0 to slave 1
        addr[0] = 8'h41; trans[0] = 2'b10; req = 3'b011;
        tick();
        sresp[1] = 2'b11; srdy[1] = 1'b0; tick();
        srdy[1] = 1'b1; tick();
        sresp[1] = 2'b00; tick(); tick();
        chk("R10 split master excluded", 64'(m_grant), 64'(3'b010));
        resume[1*NM + 0] = 1'b1; tick();
        resume = '0; tick(); tick();
        chk("R10 resumed master wins", 64'(m_grant), 64'(3'b001));

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            req = NM'($urandom);
            wr  = NM'($urandom);
            for (int m = 0; m < NM; m++) begin
                addr[m] = AW'($urandom); trans[m] = 2'($urandom); wd[m] = DW'($urandom);
            end
            for (int s = 0; s < NS; s++) begin
                int r = int'($urandom % 16);
                sd[s] = DW'($urandom);
                srdy[s] = ($urandom % 4) != 0;
                sresp[s] = (r < 11) ? 2'b00 : (r < 13) ? 2'b01 : (r < 14) ? 2'b10 : 2'b11;
            end
            resume = (($urandom % 6) == 0) ? (NS*NM)'($urandom) : '0;
            tick();
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule